// File: doc/BRIEF.md
# Reservation Station Pool with Result Broadcast Snooping

This block keeps a small set of issue slots for one class of execution unit. It holds each issued operation until both operands are present, then starts it on a single execution unit with a fixed latency per operation. An issue request carries an opcode and, for each source operand, either a literal value or the tag of the station that will produce it. A tag of zero means that the value field is already valid. Slots that are still waiting watch one shared result bus. When the tag on the bus matches an operand they are missing, they take the data from the bus. Execution therefore follows operand readiness, not issue order.

Each slot runs a three-state machine. SL_FREE goes to SL_WAIT on allocation. SL_WAIT goes to SL_EXEC when the slot is launched. SL_EXEC goes back to SL_FREE when the slot's result appears on the bus. The execution unit has its own machine. EX_IDLE goes to EX_RUN on a launch. EX_RUN goes to EX_HOLD when the latency count runs out. EX_HOLD goes back to EX_IDLE when the bus carries the unit's result tag. The result stays offered on the result outputs until an outside arbiter places it on the bus, and the slot is released in that same cycle.

Top module: `rsv_pool`

## Requirements
- R1: After reset, every slot is free and `pool_full`, `disp_valid` and `res_valid` are low.
- R2: An accepted issue goes to the free slot with the lowest index. `iss_slot_tag` shows that slot's tag, which is TAG_BASE plus the slot index (1, 2 and 3 with the defaults), and it shows 0 while the pool is full.
- R3: An operand whose tag is 0 is taken as a value. A slot is eligible to dispatch only when both of its operand tags are 0.
- R4: A waiting slot whose operand tag equals `bc_tag` while `bc_valid` is high stores `bc_data` in that operand at the clock edge and clears the tag. Both operands can be captured in the same cycle.
- R5: If an issuing operand's nonzero tag equals the broadcast tag in the same cycle, the slot stores the broadcast data and a tag of 0.
- R6: `pool_full` is high exactly when no slot is free. An issue request made while it is high is dropped. A slot that is freed at an edge can be allocated only from the next cycle.
- R7: When several slots are eligible at once, the one issued earliest is dispatched. `disp_valid` and `disp_tag` name it in the cycle of the launch.
- R8: Only one operation is in the execution unit at a time. No dispatch happens while an operation is running or while its result is waiting for the bus.
- R9: `res_valid` rises exactly L clock edges after the dispatch edge. L is 3 for add (opcode 0) and subtract (opcode 1), 10 for multiply (opcode 2) and 40 for divide (opcode 3).
- R10: The result is a+b, a-b, the low 64 bits of a*b, or unsigned a/b, where a is the first operand. Division by zero gives all ones.
- R11: `res_valid`, `res_tag` and `res_data` stay stable until the bus carries `res_tag` with `bc_valid`. At that edge the slot becomes free and the unit becomes idle.
- R12: A broadcast whose tag is 0 changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Opcode: 0 add, 1 sub, 2 mul, 3 div |
| iss_a_val | input | 64 | First operand value, used when its tag is 0 |
| iss_a_tag | input | 4 | First operand producer tag, 0 means ready |
| iss_b_val | input | 64 | Second operand value, used when its tag is 0 |
| iss_b_tag | input | 4 | Second operand producer tag, 0 means ready |
| pool_full | output | 1 | No free slot, so issue is refused |
| iss_slot_tag | output | 4 | Tag that an accepted issue receives this cycle |
| bc_valid | input | 1 | Result broadcast is valid |
| bc_tag | input | 4 | Tag of the producer of the broadcast |
| bc_data | input | 64 | Broadcast result data |
| disp_valid | output | 1 | A slot is launched this cycle |
| disp_tag | output | 4 | Tag of the launched slot |
| res_valid | output | 1 | Finished result waiting for the bus |
| res_tag | output | 4 | Tag of the finished slot |
| res_data | output | 64 | Finished result value |

## Verification
The hardest case to reach is a set of slots that all become eligible on the same broadcast while their issue order differs from their slot index. Only that case shows whether the earliest-issued slot wins. The stimulus builds it on purpose. It fills slots one and two with operations that wait on an outside tag, waits for slot zero to free, and refills slot zero with a third waiter. One broadcast then releases all three, and the launch order must be 2, 3, 1. The same-cycle forwarding case is also built directly. An issue names a tag in the same cycle that the bus carries it. A long random phase follows. It mixes literal values, outside tags, tags of busy slots, broadcasts with tag zero, zero divisors and a delayed grant of the unit's own result.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } rsv_op_e;

    typedef enum logic [1:0] {
        SL_FREE,
        SL_WAIT,
        SL_EXEC
    } slot_st_e;

    typedef enum logic [1:0] {
        EX_IDLE,
        EX_RUN,
        EX_HOLD
    } ex_st_e;

endpackage

// File: rtl/rsv_slot.sv
module rsv_slot
    import rsv_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  rsv_op_e           alloc_op,
    input  logic [DATA_W-1:0] alloc_a,
    input  logic [TAG_W-1:0]  alloc_qa,
    input  logic [DATA_W-1:0] alloc_b,
    input  logic [TAG_W-1:0]  alloc_qb,
    input  logic              launch,
    input  logic              free_i,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output slot_st_e          st,
    output logic              ready,
    output rsv_op_e           op,
    output logic [DATA_W-1:0] va,
    output logic [DATA_W-1:0] vb
);

    slot_st_e          st_n;
    logic [TAG_W-1:0]  qa;
    logic [TAG_W-1:0]  qb;
    logic              snoop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SL_FREE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            SL_FREE: if (alloc)  st_n = SL_WAIT;
            SL_WAIT: if (launch) st_n = SL_EXEC;
            SL_EXEC: if (free_i) st_n = SL_FREE;
            default:             st_n = SL_FREE;
        endcase
    end

    assign snoop = (st == SL_WAIT) && bc_valid && (bc_tag != '0);

    // operand fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op <= OP_ADD;
            va <= '0;
            vb <= '0;
            qa <= '0;
            qb <= '0;
        end else if (alloc && st == SL_FREE) begin
            op <= alloc_op;
            va <= alloc_a;
            vb <= alloc_b;
            qa <= alloc_qa;
            qb <= alloc_qb;
        end else if (snoop) begin
            if (qa == bc_tag) begin
                va <= bc_data;
                qa <= '0;
            end
            if (qb == bc_tag) begin
                vb <= bc_data;
                qb <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        ready = (st == SL_WAIT) && (qa == '0) && (qb == '0);
    end

endmodule

// File: rtl/rsv_pick.sv
module rsv_pick #(
    parameter int N     = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     busy,
    input  logic [N-1:0]     ready,
    input  logic             alloc,
    input  logic [IDX_W-1:0] alloc_idx,
    output logic             free_any,
    output logic [IDX_W-1:0] free_idx,
    output logic             pick_valid,
    output logic [IDX_W-1:0] pick_idx
);

    // older[r][c] set: slot r was issued before slot c
    logic [N-1:0] older [N];
    logic [N-1:0] beaten;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++) older[r] <= '0;
        end else if (alloc) begin
            for (int r = 0; r < N; r++) begin
                if (r == int'(alloc_idx)) older[r] <= '0;
                else                      older[r][alloc_idx] <= busy[r];
            end
        end
    end

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        beaten = '0;
        for (int c = 0; c < N; c++) begin
            for (int r = 0; r < N; r++) begin
                if (ready[r] && older[r][c]) beaten[c] = 1'b1;
            end
        end
    end

    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (ready[i] && !beaten[i]) begin
                pick_valid = 1'b1;
                pick_idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rsv_exec.sv
module rsv_exec
    import rsv_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int TAG_W   = 4,
    parameter int IDX_W   = 2,
    parameter int LAT_ADD = 3,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  rsv_op_e           start_op,
    input  logic [DATA_W-1:0] start_a,
    input  logic [DATA_W-1:0] start_b,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [TAG_W-1:0]  start_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    output logic              idle,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_data,
    output logic              retire,
    output logic [IDX_W-1:0]  retire_idx
);

    localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ?
                             ((LAT_DIV > LAT_ADD) ? LAT_DIV : LAT_ADD) :
                             ((LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD);
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    ex_st_e            st;
    ex_st_e            st_n;
    logic [CNT_W-1:0]  cnt;
    logic              accept;

    function automatic logic [CNT_W-1:0] load_of(input rsv_op_e o);
        unique case (o)
            OP_ADD, OP_SUB: load_of = CNT_W'(LAT_ADD - 1);
            OP_MUL:         load_of = CNT_W'(LAT_MUL - 1);
            default:        load_of = CNT_W'(LAT_DIV - 1);
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] calc(input rsv_op_e o,
                                               input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
        unique case (o)
            OP_ADD:  calc = a + b;
            OP_SUB:  calc = a - b;
            OP_MUL:  calc = a * b;
            default: calc = (b == '0) ? '1 : a / b;
        endcase
    endfunction

    assign accept = (st == EX_HOLD) && bc_valid && (bc_tag == res_tag);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= EX_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            EX_IDLE: if (start)       st_n = EX_RUN;
            EX_RUN:  if (cnt == '0)   st_n = EX_HOLD;
            EX_HOLD: if (accept)      st_n = EX_IDLE;
            default:                  st_n = EX_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            res_data   <= '0;
            res_tag    <= '0;
            retire_idx <= '0;
        end else if (st == EX_IDLE && start) begin
            cnt        <= load_of(start_op);
            res_data   <= calc(start_op, start_a, start_b);
            res_tag    <= start_tag;
            retire_idx <= start_idx;
        end else if (st == EX_RUN && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // outputs
    always_comb begin
        idle      = (st == EX_IDLE);
        res_valid = (st == EX_HOLD);
        retire    = accept;
    end

endmodule

// File: rtl/rsv_pool.sv
module rsv_pool
    import rsv_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    parameter int DATA_W    = 64,
    parameter int TAG_W     = 4,
    parameter int TAG_BASE  = 1,
    parameter int LAT_ADD   = 3,
    parameter int LAT_MUL   = 10,
    parameter int LAT_DIV   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [1:0]        iss_op,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    input  logic [TAG_W-1:0]  iss_b_tag,
    output logic              pool_full,
    output logic [TAG_W-1:0]  iss_slot_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              disp_valid,
    output logic [TAG_W-1:0]  disp_tag,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_data
);

    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    slot_st_e          slot_st  [NUM_SLOTS];
    rsv_op_e           slot_op  [NUM_SLOTS];
    logic [DATA_W-1:0] slot_va  [NUM_SLOTS];
    logic [DATA_W-1:0] slot_vb  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] busy_vec;
    logic [NUM_SLOTS-1:0] ready_vec;
    logic [NUM_SLOTS-1:0] exec_vec;

    logic              free_any;
    logic [IDX_W-1:0]  free_idx;
    logic              pick_valid;
    logic [IDX_W-1:0]  pick_idx;
    logic              iss_take;
    logic              disp_go;
    logic              ex_idle;
    logic              ex_retire;
    logic [IDX_W-1:0]  ex_retire_idx;
    rsv_op_e           sel_op;
    logic [DATA_W-1:0] sel_a;
    logic [DATA_W-1:0] sel_b;

    logic              fwd_a;
    logic              fwd_b;
    logic [DATA_W-1:0] new_a;
    logic [DATA_W-1:0] new_b;
    logic [TAG_W-1:0]  new_qa;
    logic [TAG_W-1:0]  new_qb;

    // issue side: allocation and same-cycle forwarding
    assign iss_take     = iss_valid && free_any;
    assign pool_full    = !free_any;
    assign iss_slot_tag = free_any ? (TAG_W'(TAG_BASE) + TAG_W'(free_idx)) : '0;

    assign fwd_a  = bc_valid && (iss_a_tag != '0) && (iss_a_tag == bc_tag);
    assign fwd_b  = bc_valid && (iss_b_tag != '0) && (iss_b_tag == bc_tag);
    assign new_a  = fwd_a ? bc_data : iss_a_val;
    assign new_b  = fwd_b ? bc_data : iss_b_val;
    assign new_qa = fwd_a ? '0 : iss_a_tag;
    assign new_qb = fwd_b ? '0 : iss_b_tag;

    // dispatch side
    assign disp_go    = pick_valid && ex_idle;
    assign disp_valid = disp_go;
    assign disp_tag   = TAG_W'(TAG_BASE) + TAG_W'(pick_idx);
    assign sel_op     = slot_op[pick_idx];
    assign sel_a      = slot_va[pick_idx];
    assign sel_b      = slot_vb[pick_idx];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic rdy;
        rsv_slot #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (iss_take && (free_idx == IDX_W'(g))),
            .alloc_op (rsv_op_e'(iss_op)),
            .alloc_a  (new_a),
            .alloc_qa (new_qa),
            .alloc_b  (new_b),
            .alloc_qb (new_qb),
            .launch   (disp_go && (pick_idx == IDX_W'(g))),
            .free_i   (ex_retire && (ex_retire_idx == IDX_W'(g))),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_data  (bc_data),
            .st       (slot_st[g]),
            .ready    (rdy),
            .op       (slot_op[g]),
            .va       (slot_va[g]),
            .vb       (slot_vb[g])
        );
        assign busy_vec[g]  = (slot_st[g] != SL_FREE);
        assign exec_vec[g]  = (slot_st[g] == SL_EXEC);
        assign ready_vec[g] = rdy;
    end

    rsv_pick #(
        .N     (NUM_SLOTS),
        .IDX_W (IDX_W)
    ) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy_vec),
        .ready      (ready_vec),
        .alloc      (iss_take),
        .alloc_idx  (free_idx),
        .free_any   (free_any),
        .free_idx   (free_idx),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    rsv_exec #(
        .DATA_W  (DATA_W),
        .TAG_W   (TAG_W),
        .IDX_W   (IDX_W),
        .LAT_ADD (LAT_ADD),
        .LAT_MUL (LAT_MUL),
        .LAT_DIV (LAT_DIV)
    ) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (disp_go),
        .start_op   (sel_op),
        .start_a    (sel_a),
        .start_b    (sel_b),
        .start_idx  (pick_idx),
        .start_tag  (disp_tag),
        .bc_valid   (bc_valid),
        .bc_tag     (bc_tag),
        .idle       (ex_idle),
        .res_valid  (res_valid),
        .res_tag    (res_tag),
        .res_data   (res_data),
        .retire     (ex_retire),
        .retire_idx (ex_retire_idx)
    );

endmodule

// File: rtl/rsv_pool_chk.sv
module rsv_pool_chk #(
    parameter int N       = 3,
    parameter int DATA_W  = 64,
    parameter int TAG_W   = 4,
    parameter int LAT_ADD = 3,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pool_full,
    input logic [TAG_W-1:0]  iss_slot_tag,
    input logic              bc_valid,
    input logic [TAG_W-1:0]  bc_tag,
    input logic              disp_valid,
    input logic [1:0]        disp_op,
    input logic              res_valid,
    input logic [TAG_W-1:0]  res_tag,
    input logic [DATA_W-1:0] res_data,
    input logic [N-1:0]      exec_vec
);

    logic [15:0] since;
    logic [15:0] want;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= '0;
            want  <= '0;
        end else if (disp_valid) begin
            since <= '0;
            case (disp_op)
                2'd0, 2'd1: want <= 16'(LAT_ADD);
                2'd2:       want <= 16'(LAT_MUL);
                default:    want <= 16'(LAT_DIV);
            endcase
        end else if (!res_valid && since != 16'hFFFF) begin
            since <= since + 16'd1;
        end
    end

    // R8
    disp_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> !res_valid);

    // R8
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !disp_valid);

    // R8
    single_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exec_vec));

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> since == want);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !(bc_valid && bc_tag == res_tag))
        |=> (res_valid && $stable(res_tag) && $stable(res_data)));

    // R2
    free_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pool_full |-> iss_slot_tag != '0);

endmodule

bind rsv_pool rsv_pool_chk #(
    .N       (NUM_SLOTS),
    .DATA_W  (DATA_W),
    .TAG_W   (TAG_W),
    .LAT_ADD (LAT_ADD),
    .LAT_MUL (LAT_MUL),
    .LAT_DIV (LAT_DIV)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pool_full    (pool_full),
    .iss_slot_tag (iss_slot_tag),
    .bc_valid     (bc_valid),
    .bc_tag       (bc_tag),
    .disp_valid   (disp_valid),
    .disp_op      (sel_op),
    .res_valid    (res_valid),
    .res_tag      (res_tag),
    .res_data     (res_data),
    .exec_vec     (exec_vec)
);

// File: tb/rsv_pool_tb.sv
`timescale 1ns/1ps
module rsv_pool_tb;

    localparam int NSL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_op = '0;
    logic [63:0] iss_a_val = '0;
    logic [3:0]  iss_a_tag = '0;
    logic [63:0] iss_b_val = '0;
    logic [3:0]  iss_b_tag = '0;
    logic        bc_valid = 1'b0;
    logic [3:0]  bc_tag = '0;
    logic [63:0] bc_data = '0;
    logic        pool_full;
    logic [3:0]  iss_slot_tag;
    logic        disp_valid;
    logic [3:0]  disp_tag;
    logic        res_valid;
    logic [3:0]  res_tag;
    logic [63:0] res_data;

    always #2.5 clk = ~clk;

    rsv_pool u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
        .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
        .pool_full(pool_full), .iss_slot_tag(iss_slot_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .disp_valid(disp_valid), .disp_tag(disp_tag),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural model state
    int          m_st  [NSL];   // 0 free, 1 waiting, 2 executing
    logic [1:0]  m_op  [NSL];
    logic [63:0] m_va  [NSL];
    logic [63:0] m_vb  [NSL];
    logic [3:0]  m_qa  [NSL];
    logic [3:0]  m_qb  [NSL];
    int          m_seq [NSL];
    int          seq_ctr;
    int          ex_mode;       // 0 idle, 1 running, 2 result waiting
    int          ex_left;
    int          ex_slot;
    logic [63:0] ex_val;

    // expected outputs for the current cycle
    bit          e_full, e_dv, e_rv;
    logic [3:0]  e_tag, e_dtag, e_rtag;
    logic [63:0] e_rdata;
    int          e_free, e_ds;

    // stimulus requests
    bit          d_iv;
    logic [1:0]  d_op;
    logic [63:0] d_av, d_bv, d_bcd;
    logic [3:0]  d_at, d_bt, d_bct;
    bit          d_bcv;
    int          own_pct = 100;

    function automatic int lat_of(input logic [1:0] o);
        if (o == 2'd2) return 10;
        if (o == 2'd3) return 40;
        return 3;
    endfunction

    function automatic logic [63:0] ref_calc(input logic [1:0] o,
                                             input logic [63:0] a,
                                             input logic [63:0] b);
        case (o)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a * b;
            default: return (b == 64'd0) ? {64{1'b1}} : a / b;
        endcase
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NSL; k++) begin
            m_st[k] = 0; m_qa[k] = 0; m_qb[k] = 0; m_seq[k] = 0;
            m_va[k] = 0; m_vb[k] = 0; m_op[k] = 0;
        end
        seq_ctr = 0; ex_mode = 0; ex_left = 0; ex_slot = 0; ex_val = 0;
    endtask

    task automatic model_outputs();
        int best;
        e_free = -1;
        for (int k = NSL - 1; k >= 0; k--) if (m_st[k] == 0) e_free = k;
        e_full = (e_free < 0);
        e_tag  = e_full ? 4'd0 : 4'(e_free + 1);
        e_dv = 0; e_ds = 0; best = 0;
        if (ex_mode == 0) begin
            for (int k = 0; k < NSL; k++) begin
                if (m_st[k] == 1 && m_qa[k] == 0 && m_qb[k] == 0) begin
                    if (!e_dv || m_seq[k] < best) begin
                        e_dv = 1; e_ds = k; best = m_seq[k];
                    end
                end
            end
        end
        e_dtag  = 4'(e_ds + 1);
        e_rv    = (ex_mode == 2);
        e_rtag  = 4'(ex_slot + 1);
        e_rdata = ex_val;
    endtask

    task automatic model_update();
        bit accepted;
        accepted = d_bcv && e_rv && (d_bct == e_rtag);
        for (int k = 0; k < NSL; k++) begin
            if (m_st[k] == 1 && d_bcv && d_bct != 0) begin
                if (m_qa[k] == d_bct) begin m_va[k] = d_bcd; m_qa[k] = 0; end
                if (m_qb[k] == d_bct) begin m_vb[k] = d_bcd; m_qb[k] = 0; end
            end
        end
        if (e_dv) begin
            m_st[e_ds] = 2;
            ex_mode = 1; ex_left = lat_of(m_op[e_ds]); ex_slot = e_ds;
            ex_val  = ref_calc(m_op[e_ds], m_va[e_ds], m_vb[e_ds]);
        end else if (ex_mode == 1) begin
            ex_left--;
            if (ex_left == 0) ex_mode = 2;
        end else if (ex_mode == 2 && accepted) begin
            ex_mode = 0;
            m_st[ex_slot] = 0;
        end
        if (d_iv && !e_full) begin
            m_st[e_free] = 1; m_op[e_free] = d_op; m_seq[e_free] = seq_ctr++;
            if (d_at != 0 && d_bcv && d_at == d_bct) begin m_va[e_free] = d_bcd; m_qa[e_free] = 0; end
            else begin m_va[e_free] = d_av; m_qa[e_free] = d_at; end
            if (d_bt != 0 && d_bcv && d_bt == d_bct) begin m_vb[e_free] = d_bcd; m_qb[e_free] = 0; end
            else begin m_vb[e_free] = d_bv; m_qb[e_free] = d_bt; end
        end
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_req();
        d_iv = 0; d_op = 0; d_av = 0; d_bv = 0; d_at = 0; d_bt = 0;
        d_bcv = 0; d_bct = 0; d_bcd = 0;
    endtask

    // one clock: drive, compare against the model, advance the model
    task automatic step();
        @(negedge clk);
        model_outputs();
        if (e_rv && !d_bcv && ($urandom % 100) < own_pct) begin
            d_bcv = 1; d_bct = e_rtag; d_bcd = e_rdata;
        end
        iss_valid = d_iv; iss_op = d_op;
        iss_a_val = d_av; iss_a_tag = d_at; iss_b_val = d_bv; iss_b_tag = d_bt;
        bc_valid = d_bcv; bc_tag = d_bct; bc_data = d_bcd;
        #1;
        chk("R6 pool_full", 64'(pool_full), 64'(e_full));
        chk("R2 iss_slot_tag", 64'(iss_slot_tag), 64'(e_tag));
        chk("R3 R8 disp_valid", 64'(disp_valid), 64'(e_dv));
        if (e_dv) chk("R7 disp_tag", 64'(disp_tag), 64'(e_dtag));
        chk("R9 R11 res_valid", 64'(res_valid), 64'(e_rv));
        if (e_rv) begin
            chk("R11 res_tag", 64'(res_tag), 64'(e_rtag));
            chk("R10 R4 R5 R12 res_data", res_data, e_rdata);
        end
        @(posedge clk);
        model_update();
        clear_req();
    endtask

    task automatic issue(input logic [1:0] o, input logic [63:0] av, input logic [3:0] at,
                         input logic [63:0] bv, input logic [3:0] bt);
        d_iv = 1; d_op = o; d_av = av; d_at = at; d_bv = bv; d_bt = bt;
        step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic rand_src(output logic [63:0] v, output logic [3:0] t);
        int r;
        int k;
        r = $urandom % 4;
        v = (($urandom % 5) == 0) ? 64'd0 : {$urandom, $urandom};
        t = 0;
        if (r == 2) t = 4'(8 + $urandom % 4);
        else if (r == 3) begin
            k = $urandom % NSL;
            if (m_st[k] != 0) t = 4'(k + 1);
        end
    endtask

    initial begin
        int r;
        clear_req();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 pool_full after reset", 64'(pool_full), 64'd0);
        chk("R1 disp_valid after reset", 64'(disp_valid), 64'd0);
        chk("R1 res_valid after reset", 64'(res_valid), 64'd0);
        chk("R2 first tag after reset", 64'(iss_slot_tag), 64'd1);

        // R7 ordering: slots ready together, issue order 2,3,1
        own_pct = 100;
        issue(2'd0, 64'd5, 4'd0, 64'd7, 4'd0);
        issue(2'd0, 64'd0, 4'd9, 64'd11, 4'd0);
        issue(2'd1, 64'd50, 4'd0, 64'd0, 4'd9);
        idle(6);
        issue(2'd2, 64'd0, 4'd9, 64'd3, 4'd0);
        idle(2);
        d_bcv = 1; d_bct = 4'd9; d_bcd = 64'd100;
        step();
        idle(40);

        // R5 forwarding at issue, both operands
        d_bcv = 1; d_bct = 4'd10; d_bcd = 64'd21;
        issue(2'd0, 64'hDEAD, 4'd10, 64'hBEEF, 4'd10);
        idle(8);

        // R6 full pool refuses issue; R4 two operands on one broadcast; R10 zero divisor
        issue(2'd3, 64'd0, 4'd11, 64'd0, 4'd11);
        issue(2'd3, 64'd1000, 4'd0, 64'd0, 4'd11);
        issue(2'd3, 64'd77, 4'd0, 64'd0, 4'd0);
        issue(2'd0, 64'd1, 4'd0, 64'd1, 4'd0);
        // R12 tag-zero broadcast is ignored
        d_bcv = 1; d_bct = 4'd0; d_bcd = 64'hFFFF;
        step();
        d_bcv = 1; d_bct = 4'd11; d_bcd = 64'd40;
        step();
        idle(160);

        // R11 delayed grant, random mix
        own_pct = 40;
        for (int c = 0; c < 4000; c++) begin
            if (($urandom % 3) != 0) begin
                d_iv = 1; d_op = 2'($urandom % 4);
                rand_src(d_av, d_at);
                rand_src(d_bv, d_bt);
            end
            r = $urandom % 8;
            if (r < 2) begin
                d_bcv = 1; d_bct = 4'(8 + $urandom % 4); d_bcd = {$urandom, $urandom};
            end else if (r == 2) begin
                d_bcv = 1; d_bct = 4'd0; d_bcd = {$urandom, $urandom};
            end
            step();
        end
        own_pct = 100;
        for (int c = 0; c < 300; c++) begin
            d_bcv = 1; d_bct = 4'(8 + c % 4); d_bcd = 64'(c);
            step();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule